// File: doc/BRIEF.md
# External SRAM FIFO Controller

This block builds a deep first-in first-out buffer whose storage is an external single-port asynchronous SRAM. The producer and consumer each see a plain synchronous valid/ready interface with 16-bit words. One controller clock runs about five times faster than the data rate on either side. That margin lets a small sequencer interleave SRAM writes and reads on the one shared address and data bus.

Two small on-chip staging FIFOs sit between the user ports and the SRAM, one on the write side and one on the read side. A registered output word sits in front of the consumer. The write and read SRAM addresses are kept apart and multiplexed onto the bus. The SRAM is full when a write brings the addresses together, and empty when a read does.

Top module: `sram_fifo_ctrl`

## Requirements
- R1: Every word accepted on the write port appears exactly once on the read port, in the order it was accepted.
- R2: Each SRAM access takes two cycles with chip enable low. A write drives the data bus and holds write enable low in its first cycle only, and keeps the address and data unchanged in its second cycle. A read holds output enable low and the address unchanged for both cycles. Write enable and output enable are never low together.
- R3: SRAM writes go to consecutive addresses starting at 0, and so do SRAM reads. Both wrap from 2^ADDR_W-1 back to 0.
- R4: A cycle with output enable low is never directly followed by a cycle in which the controller drives the data bus.
- R5: `sram_full` is 1 exactly when the last write made the write and read addresses equal. `sram_empty` is 1 exactly when the last read made them equal, or after reset. The two are never 1 together.
- R6: A read access is started when the SRAM is not empty and the read staging buffer, counting any read still in flight, holds fewer than half its depth. Otherwise a write access is started when the write staging buffer holds data and the SRAM is not full. With the consumer stalled, the block therefore accepts exactly 2^ADDR_W + STAGE_DEPTH + STAGE_DEPTH/2 + 1 words.
- R7: `wr_ready` is 0 while the write staging buffer is full. A word offered while `wr_ready` is 0 is not taken.
- R8: During and right after reset: `wr_ready`=1, `rd_valid`=0, `sram_empty`=1, `sram_full`=0, all SRAM strobes high, and the data bus not driven.
- R9: While `rd_valid` is 1 and `rd_ready` is 0, `rd_data` holds its value. When words are already buffered on chip, they are delivered on consecutive cycles without waiting for an SRAM access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Producer offers a word |
| wr_ready | output | 1 | Controller can take a word |
| wr_data | input | DATA_W | Producer word |
| rd_valid | output | 1 | Output word is valid |
| rd_ready | input | 1 | Consumer takes the word |
| rd_data | output | DATA_W | Output word |
| sram_full | output | 1 | External memory holds 2^ADDR_W words |
| sram_empty | output | 1 | External memory holds no words |
| sram_addr | output | ADDR_W | SRAM address bus |
| sram_dq_out | output | DATA_W | Data driven toward the SRAM |
| sram_dq_in | input | DATA_W | Data returned by the SRAM |
| sram_dq_oe | output | 1 | Controller drives the data bus |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |

## Verification
The bench builds the block with ADDR_W=4 and STAGE_DEPTH=4, so the SRAM holds sixteen words and the whole FIFO holds twenty-three. A stalled-consumer fill then reaches the exact capacity, and the full flag, the back-pressure and the read-side watermark can all be seen in a few dozen cycles. The same small address space lets thousands of words pass through, so both addresses wrap many times. A sweep over every pairing of four producer duty levels and four consumer duty levels drives all sequencer transitions, including read-to-write turnarounds and back-to-back reads.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_WR1,
      SQ_WR2,
      SQ_RD1,
      SQ_RD2,
      SQ_TURN
   } seq_state_t;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_WRITE,
      OP_READ
   } seq_op_t;

endpackage

// File: rtl/sfc_stage.sv
// Small on-chip staging FIFO; the head word is visible combinationally.
module sfc_stage #(
   parameter  int W     = 16,
   parameter  int DEPTH = 4,
   localparam int PW    = $clog2(DEPTH),
   localparam int CW    = PW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign head  = mem[rp];
   assign count = cnt;
   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);

   // R7: no word is ever written into a full staging buffer
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
      push |-> !full);

   // R1: no word is ever removed from an empty staging buffer
   a_r1_no_underflow: assert property (@(posedge clk) disable iff (rst)
      pop |-> !empty);

endmodule

// File: rtl/sfc_arb.sv
// Chooses the next SRAM access from the staging-buffer fill and memory flags.
module sfc_arb
   import sfc_pkg::*;
#(
   parameter  int RDEPTH = 4,
   localparam int CW     = $clog2(RDEPTH) + 1
) (
   input  logic          wstage_empty,
   input  logic          mem_full,
   input  logic          mem_empty,
   input  logic [CW-1:0] rfill,
   output seq_op_t       op
);

   localparam logic [CW-1:0] LIM  = CW'(RDEPTH);
   localparam logic [CW-1:0] HALF = CW'(RDEPTH / 2);

   logic want_rd, want_wr;

   assign want_rd = !mem_empty && (rfill < LIM) && (rfill < HALF);
   assign want_wr = !wstage_empty && !mem_full;

   always_comb begin
      if (want_rd)      op = OP_READ;
      else if (want_wr) op = OP_WRITE;
      else              op = OP_NONE;
   end

endmodule

// File: rtl/sfc_seq.sv
// SRAM access sequencer: two-cycle accesses, address multiplexing, full/empty.
module sfc_seq
   import sfc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  seq_op_t           op,
   input  logic [DATA_W-1:0] wdata,
   output logic              wpop,
   output logic              rpush,
   output logic              rd_pend,
   output logic              mem_full,
   output logic              mem_empty,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_oe,
   output logic              sram_ce_n,
   output logic              sram_we_n,
   output logic              sram_oe_n
);

   seq_state_t        state, nxt;
   logic [ADDR_W-1:0] waddr, raddr, addr_q;
   logic [DATA_W-1:0] dout_q;
   logic              last_wr, pend_q;
   logic              launch_w, launch_r, at_end;

   assign at_end = (state == SQ_IDLE) || (state == SQ_WR2) ||
                   (state == SQ_RD2)  || (state == SQ_TURN);

   always_comb begin
      nxt      = state;
      launch_w = 1'b0;
      launch_r = 1'b0;
      if (at_end) begin
         case (op)
            OP_READ: begin
               nxt      = SQ_RD1;
               launch_r = 1'b1;
            end
            OP_WRITE: begin
               if (state == SQ_RD2) nxt = SQ_TURN;
               else begin
                  nxt      = SQ_WR1;
                  launch_w = 1'b1;
               end
            end
            default: nxt = SQ_IDLE;
         endcase
      end else if (state == SQ_WR1) begin
         nxt = SQ_WR2;
      end else if (state == SQ_RD1) begin
         nxt = SQ_RD2;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= SQ_IDLE;
         waddr   <= '0;
         raddr   <= '0;
         addr_q  <= '0;
         dout_q  <= '0;
         last_wr <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         state <= nxt;
         if (launch_w) begin
            addr_q  <= waddr;
            dout_q  <= wdata;
            waddr   <= waddr + 1'b1;
            last_wr <= 1'b1;
         end
         if (launch_r) begin
            addr_q  <= raddr;
            raddr   <= raddr + 1'b1;
            last_wr <= 1'b0;
         end
         if (launch_r)             pend_q <= 1'b1;
         else if (state == SQ_RD2) pend_q <= 1'b0;
      end
   end

   assign wpop      = launch_w;
   assign rpush     = (state == SQ_RD2);
   assign rd_pend   = pend_q;
   assign mem_full  = (waddr == raddr) &&  last_wr;
   assign mem_empty = (waddr == raddr) && !last_wr;

   assign sram_addr   = addr_q;
   assign sram_dq_out = dout_q;
   assign sram_dq_oe  = (state == SQ_WR1) || (state == SQ_WR2);
   assign sram_we_n   = (state != SQ_WR1);
   assign sram_oe_n   = !((state == SQ_RD1) || (state == SQ_RD2));
   assign sram_ce_n   = !((state == SQ_WR1) || (state == SQ_WR2) ||
                          (state == SQ_RD1) || (state == SQ_RD2));

   // R2: write strobe lasts one cycle, address and data held in the second
   a_r2_we_pulse: assert property (@(posedge clk) disable iff (rst)
      !sram_we_n |=> (sram_we_n && !sram_ce_n && sram_dq_oe &&
                      $stable(sram_addr) && $stable(sram_dq_out)));

   // R2: read keeps output enable and address for its second cycle
   a_r2_rd_hold: assert property (@(posedge clk) disable iff (rst)
      (state == SQ_RD1) |=> (!sram_oe_n && !sram_ce_n && $stable(sram_addr)));

   // R2: never write and read strobes at once
   a_r2_strobe_excl: assert property (@(posedge clk) disable iff (rst)
      !(!sram_we_n && !sram_oe_n));

   // R4: bus turnaround after the SRAM has driven data
   a_r4_turnaround: assert property (@(posedge clk) disable iff (rst)
      !sram_oe_n |=> !sram_dq_oe);

   // R5: the two memory flags exclude each other
   a_r5_flags_excl: assert property (@(posedge clk) disable iff (rst)
      !(mem_full && mem_empty));

   // R5: a write can never be launched into a full memory
   a_r5_no_write_full: assert property (@(posedge clk) disable iff (rst)
      ($fell(sram_we_n) && $past(mem_full)) |-> 1'b0);

endmodule

// File: rtl/sram_fifo_ctrl.sv
// Deep FIFO stored in an external single-port SRAM.
module sram_fifo_ctrl
   import sfc_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 18,
   parameter int STAGE_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [DATA_W-1:0] wr_data,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              sram_full,
   output logic              sram_empty,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] sram_dq_out,
   input  logic [DATA_W-1:0] sram_dq_in,
   output logic              sram_dq_oe,
   output logic              sram_ce_n,
   output logic              sram_we_n,
   output logic              sram_oe_n
);

   localparam int CW = $clog2(STAGE_DEPTH) + 1;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (STAGE_DEPTH < 2 || (STAGE_DEPTH & (STAGE_DEPTH - 1)) != 0) begin : g_bad_stage
         $error("STAGE_DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic              w_push, w_pop, w_full, w_empty;
   logic [DATA_W-1:0] w_head;
   logic [CW-1:0]     w_count;

   logic              r_push, r_pop, r_full, r_empty;
   logic [DATA_W-1:0] r_head;
   logic [CW-1:0]     r_count, r_fill;

   logic              pend;
   seq_op_t           op;

   logic              out_v;
   logic [DATA_W-1:0] out_d;

   assign wr_ready = !w_full;
   assign w_push   = wr_valid && !w_full;

   sfc_stage #(.W(DATA_W), .DEPTH(STAGE_DEPTH)) u_wstage (
      .clk(clk), .rst(rst),
      .push(w_push), .push_data(wr_data),
      .pop(w_pop), .head(w_head),
      .count(w_count), .full(w_full), .empty(w_empty)
   );

   sfc_stage #(.W(DATA_W), .DEPTH(STAGE_DEPTH)) u_rstage (
      .clk(clk), .rst(rst),
      .push(r_push), .push_data(sram_dq_in),
      .pop(r_pop), .head(r_head),
      .count(r_count), .full(r_full), .empty(r_empty)
   );

   assign r_fill = r_count + CW'(pend);

   sfc_arb #(.RDEPTH(STAGE_DEPTH)) u_arb (
      .wstage_empty(w_empty),
      .mem_full(sram_full),
      .mem_empty(sram_empty),
      .rfill(r_fill),
      .op(op)
   );

   sfc_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst(rst),
      .op(op), .wdata(w_head),
      .wpop(w_pop), .rpush(r_push), .rd_pend(pend),
      .mem_full(sram_full), .mem_empty(sram_empty),
      .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
      .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n),
      .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
   );

   // prefetched output word
   assign r_pop = !r_empty && (!out_v || rd_ready);

   always_ff @(posedge clk) begin
      if (rst) begin
         out_v <= 1'b0;
         out_d <= '0;
      end else if (r_pop) begin
         out_v <= 1'b1;
         out_d <= r_head;
      end else if (rd_ready) begin
         out_v <= 1'b0;
      end
   end

   assign rd_valid = out_v;
   assign rd_data  = out_d;

   // R9: a stalled output word stays valid and unchanged
   a_r9_hold_output: assert property (@(posedge clk) disable iff (rst)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

   // R7: a full write stage refuses the producer
   a_r7_refuse: assert property (@(posedge clk) disable iff (rst)
      (w_count == CW'(STAGE_DEPTH)) |-> !wr_ready);

   // R6: read data never lands in a read stage without room
   a_r6_room: assert property (@(posedge clk) disable iff (rst)
      r_push |-> !r_full);

endmodule

// File: tb/sim_sram_fifo_ctrl.sv
module sim_sram_fifo_ctrl;

   localparam int DW  = 16;
   localparam int AW  = 4;
   localparam int SD  = 4;
   localparam int CAP = (1 << AW) + SD + SD / 2 + 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_valid = 1'b0;
   logic          wr_ready;
   logic [DW-1:0] wr_data = '0;
   logic          rd_valid;
   logic          rd_ready = 1'b0;
   logic [DW-1:0] rd_data;
   logic          sram_full, sram_empty;
   logic [AW-1:0] sram_addr;
   logic [DW-1:0] sram_dq_out, sram_dq_in;
   logic          sram_dq_oe, sram_ce_n, sram_we_n, sram_oe_n;

   int n_chk = 0;
   int n_bad = 0;

   logic [DW-1:0] mem [1 << AW];
   logic [DW-1:0] q [$];
   logic [DW-1:0] next_val = 16'h1000;
   int            exp_w = 0;
   int            exp_r = 0;
   bit            rphase = 1'b0;
   bit            prev_oe = 1'b0;
   bit            prev_we = 1'b0;

   always #10 clk = ~clk;

   sram_fifo_ctrl #(.DATA_W(DW), .ADDR_W(AW), .STAGE_DEPTH(SD)) u0 (
      .clk(clk), .rst(rst),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
      .sram_full(sram_full), .sram_empty(sram_empty),
      .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in),
      .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n),
      .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
   );

   assign sram_dq_in = (sram_ce_n === 1'b0 && sram_oe_n === 1'b0) ? mem[sram_addr] : '0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // behavioural SRAM write on the rising write strobe; R3 write address order
   always @(posedge sram_we_n) begin
      if (sram_ce_n === 1'b0) begin
         mem[sram_addr] = sram_dq_out;
         check(int'(sram_addr) == exp_w, "R3", "write address",
               int'(sram_addr), exp_w);
         exp_w = (exp_w + 1) % (1 << AW);
      end
   end

   // bus shape monitors: R2, R3 (reads), R4
   always @(negedge clk) begin
      if (!rst) begin
         if (sram_oe_n === 1'b0) begin
            check(sram_ce_n === 1'b0 && sram_we_n === 1'b1, "R2",
                  "read strobes", {sram_ce_n, sram_we_n}, 2'b01);
            if (!rphase) begin
               check(int'(sram_addr) == exp_r, "R3", "read address",
                     int'(sram_addr), exp_r);
               exp_r = (exp_r + 1) % (1 << AW);
            end
            rphase = !rphase;
         end
         if (prev_oe) check(sram_dq_oe !== 1'b1, "R4", "drive after read", sram_dq_oe, 0);
         if (prev_we) check(sram_we_n === 1'b1, "R2", "write strobe width", sram_we_n, 1);
         if (sram_full === 1'b1) check(sram_empty === 1'b0, "R5", "flags exclusive", sram_empty, 0);
         prev_oe = (sram_oe_n === 1'b0);
         prev_we = (sram_we_n === 1'b0);
      end
   end

   // one cycle of traffic; wp/rp in quarters (0..4)
   task automatic cycle_once(input int wp, input int rp);
      @(negedge clk);
      wr_valid = ($urandom_range(0, 3) < wp);
      rd_ready = ($urandom_range(0, 3) < rp);
      wr_data  = next_val;
      #1;
      if (wr_valid && wr_ready) begin
         q.push_back(wr_data);
         next_val = next_val + 1'b1;
      end
      if (rd_valid && rd_ready) begin
         if (q.size() == 0) begin
            check(1'b0, "R1", "word with nothing accepted", rd_data, 0);
         end else begin
            logic [DW-1:0] e;
            e = q.pop_front();
            check(rd_data == e, "R1", "read order", rd_data, e);
         end
      end
   endtask

   initial begin
      int acc;
      bit saw_low;
      logic [DW-1:0] held;

      repeat (3) @(posedge clk);
      @(negedge clk);
      check(wr_ready === 1'b1, "R8", "wr_ready in reset", wr_ready, 1);
      check(rd_valid === 1'b0, "R8", "rd_valid in reset", rd_valid, 0);
      check(sram_empty === 1'b1 && sram_full === 1'b0, "R8", "flags in reset",
            {sram_full, sram_empty}, 2'b01);
      check({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe} === 4'b1110, "R8",
            "strobes in reset", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);
      rst = 1'b0;
      @(negedge clk);
      check(sram_empty === 1'b1 && wr_ready === 1'b1 && rd_valid === 1'b0, "R8",
            "state after reset", {sram_empty, wr_ready, rd_valid}, 3'b110);

      // fill with a stalled consumer
      acc = q.size();
      repeat (120) cycle_once(4, 0);
      held = rd_data;
      repeat (80) cycle_once(4, 0);
      check(q.size() - acc == CAP, "R6", "words taken at capacity", q.size() - acc, CAP);
      check(wr_ready === 1'b0, "R7", "ready low at capacity", wr_ready, 0);
      check(q.size() - acc == CAP, "R7", "offered words refused", q.size() - acc, CAP);
      check(sram_full === 1'b1 && sram_empty === 1'b0, "R5", "full at capacity",
            {sram_full, sram_empty}, 2'b10);
      check(rd_valid === 1'b1 && rd_data == held, "R9", "stalled word held", rd_data, held);

      // three buffered words leave back to back
      for (int i = 0; i < 3; i++) begin
         cycle_once(0, 4);
         check(rd_valid === 1'b1, "R9", "back-to-back delivery", rd_valid, 1);
      end
      saw_low = 1'b0;
      for (int i = 0; i < 10; i++) begin
         cycle_once(0, 0);
         if (sram_full === 1'b0) saw_low = 1'b1;
      end
      check(saw_low, "R5", "full clears after a read", saw_low, 1);

      // drain completely
      repeat (200) cycle_once(0, 4);
      check(q.size() == 0, "R1", "all words delivered", q.size(), 0);
      check(sram_empty === 1'b1 && sram_full === 1'b0, "R5", "empty after drain",
            {sram_full, sram_empty}, 2'b01);
      check(rd_valid === 1'b0 && wr_ready === 1'b1, "R5", "idle after drain",
            {rd_valid, wr_ready}, 2'b01);

      // duty-cycle sweep
      for (int wp = 1; wp <= 4; wp++) begin
         for (int rp = 1; rp <= 4; rp++) begin
            repeat (400) cycle_once(wp, rp);
         end
      end
      repeat (300) cycle_once(0, 4);
      check(q.size() == 0, "R1", "sweep fully delivered", q.size(), 0);
      check(sram_empty === 1'b1, "R5", "empty after sweep", sram_empty, 1);
      check(exp_w == exp_r, "R3", "write and read address agree", exp_r, exp_w);

      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "R1", "watchdog expired", 0, 1);
      summary();
   end

endmodule